// File: doc/BRIEF.md
# FM Floppy Read-Data Separator

This block takes the raw pulse train read from a single-density (FM) floppy head, together with the drive's index pulse. Both inputs are asynchronous to the system clock and are sampled by it. Every bit cell opens with a clock pulse. A second pulse near the middle of the cell marks a one, and a cell with no middle pulse holds a zero. The block measures the spacing between successive clock pulses and judges each later pulse against that measured spacing. Because of this, the data window follows a cell period that drifts slowly, and no fixed sampling rate is assumed.

A one-cycle `go` pulse loads a requested sector count. The reader then waits for the rising edge of the index pulse. From the first clock pulse after that edge, bits are gathered into bytes, least significant bit first. Each finished byte is written to a byte-wide memory port at consecutive addresses starting from zero. When the requested number of sectors has been stored, `done` rises. If the index pulse comes back before the transfer completes, or if the pulse train stops, `err` rises instead. Both flags stay set until the next `go`.

Top module: `fm_floppy_reader`

## Requirements
- R1: After reset, `done`, `err` and `mem_we` are all low.
- R2: After `go`, pulses on `rd_in` that arrive before the next rising edge of `idx_in` produce no memory writes. The first clock pulse after that edge opens bit 0 of byte 0.
- R3: A pulse whose distance from the latest clock pulse lies between one quarter and three quarters of the measured clock-to-clock interval is a data pulse, and it makes that cell's bit 1. Any other pulse is the next clock pulse. A cell's bit is committed when the clock pulse of the following cell arrives.
- R4: Bits arrive least significant first. The first committed bit of a byte ends up in bit 0 of `mem_wdata`.
- R5: Each assembled byte is written with a one-cycle `mem_we` pulse. `mem_addr` starts at 0 after `go` and increases by one per byte.
- R6: The reference interval is re-measured at every clock pulse, so decoding stays correct while the cell length ramps by one clock per cell between 32 and 48 cycles (nominal 40).
- R7: `done` rises in the same cycle as the last byte write of the requested sectors (SECT_BYTES bytes each). No write occurs after `done` or `err` is set, and the two are never high together.
- R8: A rising edge of `idx_in` during a transfer that is not yet complete sets `err` and stops the transfer.
- R9: If no pulse arrives for more than 1.5 measured intervals after a clock pulse during a transfer, `err` is set. It is not set at 1.25 intervals.
- R10: `done` and `err` hold until the next `go`, which clears both of them.
- R11: A `go` with a requested count of 0 sets `done` on the next cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rd_in | input | 1 | Raw read pulse train (asynchronous) |
| idx_in | input | 1 | Drive index pulse (asynchronous) |
| go | input | 1 | One-cycle start command |
| sect_req | input | REQ_W | Number of sectors to read |
| done | output | 1 | Requested sectors stored |
| err | output | 1 | Transfer failed |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |

## Verification
The bench builds the reader with four-byte sectors and a 40-cycle nominal cell on a 50 MHz clock, and keeps the default 9-bit address, 4-bit count and two-stage synchroniser. With sectors that short, multi-sector completion, an index pulse arriving mid-transfer and a stalled pulse train all fit into a few thousand cycles. The 40-cycle cell also leaves enough resolution to ramp the period from 32 to 48 cycles and to probe the timeout on both sides of its 1.5-interval limit.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} ctl_state_t;
endpackage

// File: rtl/fmsep_sync.sv
module fmsep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fmsep_cell.sv
module fmsep_cell #(
   parameter int CNT_W    = 10,
   parameter int NOM_CELL = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pulse,
   output logic bit_valid,
   output logic bit_val,
   output logic timeout
);
   logic             have_ref;
   logic             data_seen;
   logic [CNT_W-1:0] since;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] win_lo;
   logic [CNT_W-1:0] win_hi;
   logic [CNT_W:0]   limit;
   logic             in_win;

   always_comb begin
      win_lo  = period >> 2;
      win_hi  = period - (period >> 2);
      limit   = {1'b0, period} + {2'b00, period[CNT_W-1:1]};
      in_win  = have_ref && (since >= win_lo) && (since <= win_hi);
      timeout = enable && have_ref && ({1'b0, since} > limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_ref  <= 1'b0;
         data_seen <= 1'b0;
         since     <= '0;
         period    <= CNT_W'(NOM_CELL);
         bit_valid <= 1'b0;
         bit_val   <= 1'b0;
      end else if (!enable) begin
         have_ref  <= 1'b0;
         data_seen <= 1'b0;
         since     <= '0;
         period    <= CNT_W'(NOM_CELL);
         bit_valid <= 1'b0;
      end else begin
         bit_valid <= 1'b0;
         if (pulse && in_win) begin
            data_seen <= 1'b1;
            if (since != '1) since <= since + 1'b1;
         end else if (pulse) begin
            since     <= CNT_W'(1);
            data_seen <= 1'b0;
            have_ref  <= 1'b1;
            if (have_ref) begin
               period    <= since;
               bit_valid <= 1'b1;
               bit_val   <= data_seen;
            end
         end else if (since != '1) begin
            since <= since + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fmsep_shift.sv
module fmsep_shift
   import fmsep_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bit_valid,
   input  logic              bit_val,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int BC_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sh;
   logic [BC_W-1:0]   cnt;
   logic [BYTE_W-1:0] nxt;

   assign nxt = {bit_val, sh[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh         <= '0;
         cnt        <= '0;
         byte_valid <= 1'b0;
         byte_val   <= '0;
      end else if (clear) begin
         sh         <= '0;
         cnt        <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (bit_valid) begin
            sh  <= nxt;
            cnt <= cnt + 1'b1;
            if (cnt == BC_W'(BYTE_W - 1)) begin
               byte_valid <= 1'b1;
               byte_val   <= nxt;
            end
         end
      end
   end
endmodule

// File: rtl/fm_floppy_reader.sv
module fm_floppy_reader
   import fmsep_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 10,
   parameter int NOM_CELL    = 40,
   parameter int SECT_BYTES  = 512,
   parameter int ADDR_W      = 9,
   parameter int REQ_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_in,
   input  logic              idx_in,
   input  logic              go,
   input  logic [REQ_W-1:0]  sect_req,
   output logic              done,
   output logic              err,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata
);
   localparam int BC_W = (SECT_BYTES > 1) ? $clog2(SECT_BYTES) : 1;
   localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(SECT_BYTES - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SECT_BYTES < 2 || (1 << BC_W) != SECT_BYTES) begin : g_bad_sect
         $error("SECT_BYTES must be a power of two of at least 2");
      end
      if (NOM_CELL < 8 || NOM_CELL >= (1 << (CNT_W - 1))) begin : g_bad_cell
         $error("NOM_CELL must be at least 8 and leave headroom in CNT_W");
      end
   endgenerate

   ctl_state_t        state;
   logic              rd_rise, idx_rise;
   logic              bit_valid, bit_val, timeout;
   logic              byte_valid;
   logic [BYTE_W-1:0] byte_val;
   logic [REQ_W-1:0]  req_q, scnt, scnt_nxt;
   logic [BC_W-1:0]   bcnt;
   logic [ADDR_W-1:0] wr_ptr;
   logic              running;

   assign running  = (state == ST_RUN);
   assign scnt_nxt = scnt + 1'b1;

   fmsep_sync #(.STAGES(SYNC_STAGES)) rd_sync_i (
      .clk(clk), .rst_n(rst_n), .din(rd_in), .rise(rd_rise));

   fmsep_sync #(.STAGES(SYNC_STAGES)) idx_sync_i (
      .clk(clk), .rst_n(rst_n), .din(idx_in), .rise(idx_rise));

   fmsep_cell #(.CNT_W(CNT_W), .NOM_CELL(NOM_CELL)) cell_i (
      .clk(clk), .rst_n(rst_n), .enable(running), .pulse(rd_rise),
      .bit_valid(bit_valid), .bit_val(bit_val), .timeout(timeout));

   fmsep_shift shift_i (
      .clk(clk), .rst_n(rst_n), .clear(!running),
      .bit_valid(bit_valid), .bit_val(bit_val),
      .byte_valid(byte_valid), .byte_val(byte_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         done      <= 1'b0;
         err       <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         req_q     <= '0;
         scnt      <= '0;
         bcnt      <= '0;
         wr_ptr    <= '0;
      end else begin
         mem_we <= 1'b0;
         if (go) begin
            state  <= (sect_req == '0) ? ST_IDLE : ST_ARM;
            done   <= (sect_req == '0);
            err    <= 1'b0;
            req_q  <= sect_req;
            scnt   <= '0;
            bcnt   <= '0;
            wr_ptr <= '0;
         end else begin
            case (state)
               ST_ARM: if (idx_rise) state <= ST_RUN;
               ST_RUN: begin
                  if (idx_rise || timeout) begin
                     err   <= 1'b1;
                     state <= ST_IDLE;
                  end else if (byte_valid) begin
                     mem_we    <= 1'b1;
                     mem_addr  <= wr_ptr;
                     mem_wdata <= byte_val;
                     wr_ptr    <= wr_ptr + 1'b1;
                     if (bcnt == LAST_BYTE) begin
                        bcnt <= '0;
                        scnt <= scnt_nxt;
                        if (scnt_nxt == req_q) begin
                           done  <= 1'b1;
                           state <= ST_IDLE;
                        end
                     end else begin
                        bcnt <= bcnt + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fmsep_chk.sv
module fmsep_chk #(
   parameter int REQ_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [REQ_W-1:0] sect_req,
   input logic             done,
   input logic             err,
   input logic             mem_we
);
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R7
   AST_NO_WRITE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      ((done || err) && $past(done || err)) |-> !mem_we); // R7
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !go) |=> done); // R10
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !go) |=> err); // R10
   AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (go && sect_req != '0) |=> (!done && !err)); // R10
   AST_ZERO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (go && sect_req == '0) |=> (done && !mem_we)); // R11
   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R5
endmodule

bind fm_floppy_reader fmsep_chk #(.REQ_W(REQ_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .go(go), .sect_req(sect_req),
   .done(done), .err(err), .mem_we(mem_we));

// File: tb/fm_floppy_reader_tb_top.sv
module fm_floppy_reader_tb_top;
   localparam int SECT_B = 4;
   localparam int CELL   = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_in = 1'b0;
   logic       idx_in = 1'b0;
   logic       go = 1'b0;
   logic [3:0] sect_req = '0;
   logic       done, err, mem_we;
   logic [8:0] mem_addr;
   logic [7:0] mem_wdata;

   int n_tests = 0;
   int n_fail  = 0;
   int wr_total = 0;
   logic [7:0] cap [0:511];
   logic [8:0] cap_addr [0:511];
   bit finished = 0;

   always #10 clk = ~clk;

   fm_floppy_reader #(
      .SYNC_STAGES(2), .CNT_W(10), .NOM_CELL(CELL),
      .SECT_BYTES(SECT_B), .ADDR_W(9), .REQ_W(4)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_in(rd_in), .idx_in(idx_in),
      .go(go), .sect_req(sect_req), .done(done), .err(err),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   always @(posedge clk) begin
      if (mem_we) begin
         cap[wr_total[8:0]]      <= mem_wdata;
         cap_addr[wr_total[8:0]] <= mem_addr;
         wr_total                <= wr_total + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_cell(input bit b, input int len);
      for (int c = 0; c < len; c++) begin
         rd_in = (c < 2) || (b && c >= len / 2 && c < len / 2 + 2);
         @(negedge clk);
      end
      rd_in = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input int len);
      for (int i = 0; i < 8; i++) send_cell(v[i], len);
   endtask

   task automatic index_pulse();
      idx_in = 1'b1;
      repeat (8) @(negedge clk);
      idx_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic start(input int req);
      sect_req = 4'(req);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 done", done, 0);
      chk("R1 err", err, 0);
      chk("R1 mem_we", mem_we, 0);
   endtask

   task automatic t_basic();
      logic [7:0] pat [8] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C, 8'h5A, 8'h96};
      int base;
      base = wr_total;
      start(2);
      send_byte(8'hC3, CELL);
      send_byte(8'h11, CELL);
      repeat (10) @(negedge clk);
      chk("R2 no writes before index", wr_total - base, 0);
      index_pulse();
      for (int i = 0; i < 8; i++) send_byte(pat[i], CELL);
      send_cell(1'b0, CELL);
      repeat (10) @(negedge clk);
      chk("R7 write count", wr_total - base, 8);
      chk("R7 done", done, 1);
      chk("R7 err", err, 0);
      for (int i = 0; i < 8; i++) begin
         chk("R3 R4 byte value", cap[base + i], pat[i]);
         chk("R5 address", cap_addr[base + i], i);
      end
      send_byte(8'h77, CELL);
      send_cell(1'b0, CELL);
      repeat (10) @(negedge clk);
      chk("R10 done held", done, 1);
      chk("R7 no writes after done", wr_total - base, 8);
   endtask

   task automatic t_drift();
      logic [7:0] pat [4] = '{8'h6D, 8'hB2, 8'h0F, 8'hE1};
      int base, len, dir;
      base = wr_total;
      len = 32; dir = 1;
      start(1);
      index_pulse();
      for (int i = 0; i < 4; i++) begin
         for (int k = 0; k < 8; k++) begin
            send_cell(pat[i][k], len);
            if (len == 48) dir = -1;
            if (len == 32) dir = 1;
            len += dir;
         end
      end
      send_cell(1'b0, len);
      repeat (10) @(negedge clk);
      chk("R6 write count", wr_total - base, 4);
      for (int i = 0; i < 4; i++) chk("R6 byte value", cap[base + i], pat[i]);
      chk("R6 done", done, 1);
   endtask

   task automatic t_index_again();
      int base;
      base = wr_total;
      start(2);
      chk("R10 go clears done", done, 0);
      index_pulse();
      send_byte(8'h12, CELL);
      send_byte(8'h34, CELL);
      send_cell(1'b0, CELL);
      index_pulse();
      repeat (4) @(negedge clk);
      chk("R8 err on index", err, 1);
      chk("R8 done low", done, 0);
      chk("R8 writes before index", wr_total - base, 2);
      repeat (20) @(negedge clk);
      chk("R10 err held", err, 1);
   endtask

   task automatic t_timeout();
      start(1);
      chk("R10 go clears err", err, 0);
      index_pulse();
      send_byte(8'h55, CELL);
      send_cell(1'b0, CELL);
      repeat (50 - CELL) @(negedge clk);
      chk("R9 no err at 1.25 interval", err, 0);
      repeat (30) @(negedge clk);
      chk("R9 err after 1.5 interval", err, 1);
      chk("R9 done low", done, 0);
   endtask

   task automatic t_zero();
      int base;
      base = wr_total;
      start(0);
      chk("R11 done on zero request", done, 1);
      chk("R11 err", err, 0);
      repeat (5) @(negedge clk);
      chk("R11 no writes", wr_total - base, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_drift();
      t_index_again();
      t_timeout();
      t_zero();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule